// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a byte-wide host write bus and the controller of a flash array. It watches every write strobe with its address and data. It recognises the multi-cycle unlock-and-command sequences that guard the array. For each complete and permitted sequence it emits a single-cycle command pulse, together with a latched address, data byte and sector mask. The array controller performs the actual programming and erasing. This decoder only decides what was asked for and whether it is allowed.

It also owns the read-path selector. In array mode, reads return the array data unchanged. In identifier mode, they return a manufacturer code, a device code or a per-sector protection byte, chosen by three low address bits.

A sequence goes back to array read when it contains a wrong byte or when it stalls for too long. Both time limits are counted in clock cycles, so a bench can shorten them through parameters: the gap allowed between sequence writes, and the window for adding sectors to an erase.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `cmd_valid_o` is 0, `rd_mode_o` is 0 (array mode), `erase_win_o` is 0 and `rd_data_o` equals `array_data_i`.
- R2: The writes AAh@5555h, 55h@2AAAh, A0h@5555h, followed by a write of data D at address A, give `cmd_valid_o` high for exactly one cycle, in the cycle after the write of D. During that cycle `cmd_o`=1 (program), `cmd_addr_o`=A and `cmd_data_o`=D.
- R3: The sector of an address is its top two bits, and sector s is protected when `prot_i[s]` is 1. A program whose target is in a protected sector produces no pulse and returns to array mode.
- R4: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 30h@A open the erase window (`erase_win_o`=1) with sector(A) selected. Each further 30h write at any address adds that address's sector, provided no more than WIN_CYC-1 cycles without a 30h write have passed since the previous 30h. Writes of other data in the window are ignored. After WIN_CYC cycles without a 30h write, the window closes and a pulse with `cmd_o`=2 is issued. Its `erase_mask_o` holds the selected unprotected sectors (bit s = sector s).
- R5: If every sector selected in a window is protected, the window closes without a pulse.
- R6: A sixth cycle of 10h@5555h in place of 30h issues `cmd_o`=3 with `erase_mask_o` = ~`prot_i`. It issues nothing when every sector is protected.
- R7: From array read, a single write of B0h at any address issues `cmd_o`=4 (suspend), 30h issues `cmd_o`=5 (resume), and F0h issues `cmd_o`=6 (reset).
- R8: F0h at any address as the third cycle, after the two unlock cycles, issues `cmd_o`=6 and leaves `rd_mode_o` at 0.
- R9: The two unlock cycles followed by 90h@5555h set `rd_mode_o`=1. In that mode, with (A0,A1,A6) of `rd_addr_i` equal to (0,0,0), `rd_data_o` is MFR_ID. For (1,0,0) it is DEV_ID, and for any combination other than (0,1,0) it is 00h.
- R10: In identifier mode with (A0,A1,A6)=(0,1,0), `rd_data_o` is 01h when the sector given by the top two bits of `rd_addr_i` is protected, and 00h otherwise.
- R11: A wrong data byte or wrong address in any cycle of a sequence returns the decoder to array mode (`rd_mode_o`=0) without a pulse. The remaining cycles of that sequence then have no effect.
- R12: Two consecutive writes of a sequence may be separated by up to TMO_CYC-1 cycles without a strobe. After TMO_CYC such cycles the decoder returns to array mode, and the rest of the sequence has no effect.
- R13: Only address bits 14:0 are compared with 5555h and 2AAAh, so unlock writes at 1D555h and 2AAAAh are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Write strobe, one cycle per bus write |
| addr_i | input | ADDR_W | Write address |
| data_i | input | 8 | Write data |
| prot_i | input | 2**SECT_W | Per-sector protect mask |
| rd_addr_i | input | ADDR_W | Read address |
| array_data_i | input | 8 | Data read from the array |
| rd_data_o | output | 8 | Read data after mode selection |
| rd_mode_o | output | 1 | 0 array read, 1 identifier mode |
| cmd_valid_o | output | 1 | Single-cycle command pulse |
| cmd_o | output | 3 | Command code (1..6) |
| cmd_addr_o | output | ADDR_W | Latched command address |
| cmd_data_o | output | 8 | Latched program data |
| erase_mask_o | output | 2**SECT_W | Sectors to erase |
| erase_win_o | output | 1 | Sector-add window open |

## Verification
The erase window can expire on the same edge on which a new 30h write arrives. The bench provokes this by placing an add exactly WIN_CYC-1 idle cycles after the previous one. It then judges the outcome in three ways: the window must stay open, no pulse may appear for another WIN_CYC-1 cycles, and the final mask must include the late sector. The inter-cycle timeout is probed the same way, with gaps of TMO_CYC-1 and TMO_CYC idle cycles, and only the first gap may lead to a program pulse.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [2:0] {
    CMD_NONE       = 3'd0,
    CMD_PROG       = 3'd1,
    CMD_SECT_ERASE = 3'd2,
    CMD_CHIP_ERASE = 3'd3,
    CMD_SUSPEND    = 3'd4,
    CMD_RESUME     = 3'd5,
    CMD_RESET      = 3'd6
  } fcd_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_PROG, ST_ERA3, ST_ERA4, ST_ERA5, ST_EWIN
  } fcd_state_e;

  localparam logic [14:0] KEY_ADDR1 = 15'h5555;
  localparam logic [14:0] KEY_ADDR2 = 15'h2AAA;
  localparam logic [7:0]  KEY_D1    = 8'hAA;
  localparam logic [7:0]  KEY_D2    = 8'h55;
  localparam logic [7:0]  OP_PROG   = 8'hA0;
  localparam logic [7:0]  OP_ERASE  = 8'h80;
  localparam logic [7:0]  OP_IDENT  = 8'h90;
  localparam logic [7:0]  OP_RESET  = 8'hF0;
  localparam logic [7:0]  OP_SECT   = 8'h30;
  localparam logic [7:0]  OP_CHIP   = 8'h10;
  localparam logic [7:0]  OP_SUSP   = 8'hB0;
endpackage

// File: rtl/fcd_gap_timer.sv
module fcd_gap_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clear_i)          cnt_q <= '0;
    else if (cnt_q != '1)      cnt_q <= cnt_q + CNT_W'(1);
  end

  assign expired_o = (cnt_q == limit_i - CNT_W'(1));
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int SECT_W  = 2,
  parameter int TMO_CYC = 16,
  parameter int WIN_CYC = 32,
  parameter int CNT_W   = 6,
  localparam int NSECT  = 1 << SECT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic [NSECT-1:0]  prot_i,
  input  logic              tmr_expired_i,
  output logic              tmr_clear_o,
  output logic [CNT_W-1:0]  tmr_limit_o,
  output logic              cmd_valid_o,
  output fcd_cmd_e          cmd_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [7:0]        cmd_data_o,
  output logic [NSECT-1:0]  erase_mask_o,
  output logic              ident_o,
  output logic              erase_win_o
);
  fcd_state_e        st_q, st_d;
  logic              ident_q, ident_d;
  logic [NSECT-1:0]  mask_q, mask_d;
  logic              vld_q, vld_d;
  fcd_cmd_e          cmd_q, cmd_d;
  logic [ADDR_W-1:0] caddr_q, caddr_d;
  logic [7:0]        cdata_q, cdata_d;

  logic [SECT_W-1:0] sect;
  logic [NSECT-1:0]  sect_oh;
  logic              at_k1, at_k2, in_seq, add_sect, abort;

  assign sect  = addr_i[ADDR_W-1 -: SECT_W];
  assign at_k1 = (addr_i[14:0] == KEY_ADDR1);
  assign at_k2 = (addr_i[14:0] == KEY_ADDR2);
  assign in_seq = (st_q == ST_UNL1) || (st_q == ST_UNL2) || (st_q == ST_PROG) ||
                  (st_q == ST_ERA3) || (st_q == ST_ERA4) || (st_q == ST_ERA5);
  assign add_sect = (st_q == ST_EWIN) && wr_i && (data_i == OP_SECT);

  always_comb begin
    sect_oh       = '0;
    sect_oh[sect] = 1'b1;
  end

  always_comb begin
    st_d    = st_q;
    ident_d = ident_q;
    mask_d  = mask_q;
    vld_d   = 1'b0;
    cmd_d   = cmd_q;
    caddr_d = caddr_q;
    cdata_d = cdata_q;
    abort   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (wr_i) begin
        if (at_k1 && data_i == KEY_D1) st_d = ST_UNL1;
        else if (data_i == OP_RESET) begin
          vld_d = 1'b1; cmd_d = CMD_RESET; ident_d = 1'b0;
        end else if (data_i == OP_SUSP) begin
          vld_d = 1'b1; cmd_d = CMD_SUSPEND;
        end else if (data_i == OP_SECT) begin
          vld_d = 1'b1; cmd_d = CMD_RESUME;
        end
      end
      ST_UNL1: if (wr_i) begin
        if (at_k2 && data_i == KEY_D2) st_d = ST_UNL2;
        else abort = 1'b1;
      end
      ST_UNL2: if (wr_i) begin
        if (data_i == OP_RESET) begin
          vld_d = 1'b1; cmd_d = CMD_RESET; ident_d = 1'b0; st_d = ST_IDLE;
        end else if (at_k1 && data_i == OP_PROG)  st_d = ST_PROG;
        else if (at_k1 && data_i == OP_ERASE)     st_d = ST_ERA3;
        else if (at_k1 && data_i == OP_IDENT) begin
          ident_d = 1'b1; st_d = ST_IDLE;
        end else abort = 1'b1;
      end
      ST_PROG: if (wr_i) begin
        st_d    = ST_IDLE;
        ident_d = 1'b0;
        if (!prot_i[sect]) begin
          vld_d = 1'b1; cmd_d = CMD_PROG; caddr_d = addr_i; cdata_d = data_i;
        end
      end
      ST_ERA3: if (wr_i) begin
        if (at_k1 && data_i == KEY_D1) st_d = ST_ERA4;
        else abort = 1'b1;
      end
      ST_ERA4: if (wr_i) begin
        if (at_k2 && data_i == KEY_D2) st_d = ST_ERA5;
        else abort = 1'b1;
      end
      ST_ERA5: if (wr_i) begin
        if (data_i == OP_SECT) begin
          st_d    = ST_EWIN;
          ident_d = 1'b0;
          mask_d  = sect_oh & ~prot_i;
          caddr_d = addr_i;
        end else if (at_k1 && data_i == OP_CHIP) begin
          st_d    = ST_IDLE;
          ident_d = 1'b0;
          if (!(&prot_i)) begin
            vld_d = 1'b1; cmd_d = CMD_CHIP_ERASE; mask_d = ~prot_i;
          end
        end else abort = 1'b1;
      end
      ST_EWIN: begin
        // a late add on the expiry edge keeps the window open
        if (add_sect) mask_d = mask_q | (sect_oh & ~prot_i);
        else if (tmr_expired_i) begin
          st_d = ST_IDLE;
          if (mask_q != '0) begin
            vld_d = 1'b1; cmd_d = CMD_SECT_ERASE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (in_seq && !wr_i && tmr_expired_i) abort = 1'b1;
    if (abort) begin
      st_d    = ST_IDLE;
      ident_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      ident_q <= 1'b0;
      mask_q  <= '0;
      vld_q   <= 1'b0;
      cmd_q   <= CMD_NONE;
      caddr_q <= '0;
      cdata_q <= '0;
    end else begin
      st_q    <= st_d;
      ident_q <= ident_d;
      mask_q  <= mask_d;
      vld_q   <= vld_d;
      cmd_q   <= cmd_d;
      caddr_q <= caddr_d;
      cdata_q <= cdata_d;
    end
  end

  assign tmr_clear_o  = (st_q == ST_IDLE) || (in_seq && wr_i) || add_sect;
  assign tmr_limit_o  = (st_q == ST_EWIN) ? CNT_W'(WIN_CYC) : CNT_W'(TMO_CYC);
  assign cmd_valid_o  = vld_q;
  assign cmd_o        = cmd_q;
  assign cmd_addr_o   = caddr_q;
  assign cmd_data_o   = cdata_q;
  assign erase_mask_o = mask_q;
  assign ident_o      = ident_q;
  assign erase_win_o  = (st_q == ST_EWIN);

  assert_tmo_abort_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_seq && !wr_i && tmr_expired_i |=> (st_q == ST_IDLE) && !ident_q);

  assert_mask_grows_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_EWIN) |=> ((mask_q & $past(mask_q)) == $past(mask_q)));

  assert_prot_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PROG) && wr_i && prot_i[sect] |=> !cmd_valid_o);

  assert_erase_nonempty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && (cmd_o == CMD_SECT_ERASE || cmd_o == CMD_CHIP_ERASE)
      |-> (erase_mask_o != '0));

  assert_cmd_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_o != CMD_NONE));
endmodule

// File: rtl/fcd_read_mux.sv
module fcd_read_mux #(
  parameter int         ADDR_W = 18,
  parameter int         SECT_W = 2,
  parameter logic [7:0] MFR_ID = 8'h20,
  parameter logic [7:0] DEV_ID = 8'h5C,
  localparam int        NSECT  = 1 << SECT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ident_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [7:0]        array_data_i,
  input  logic [NSECT-1:0]  prot_i,
  output logic [7:0]        rd_data_o
);
  logic [2:0]        sel;
  logic [SECT_W-1:0] rsect;
  logic              unused_addr;

  assign sel         = {rd_addr_i[6], rd_addr_i[1], rd_addr_i[0]};
  assign rsect       = rd_addr_i[ADDR_W-1 -: SECT_W];
  assign unused_addr = ^rd_addr_i;

  always_comb begin
    if (!ident_i) rd_data_o = array_data_i;
    else begin
      unique case (sel)
        3'b000:  rd_data_o = MFR_ID;
        3'b001:  rd_data_o = DEV_ID;
        3'b010:  rd_data_o = {7'd0, prot_i[rsect]};
        default: rd_data_o = 8'h00;
      endcase
    end
  end

  assert_prot_byte_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ident_i && (sel == 3'b010) |-> (rd_data_o[7:1] == 7'd0));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int         ADDR_W  = 18,
  parameter int         SECT_W  = 2,
  parameter int         TMO_CYC = 16,
  parameter int         WIN_CYC = 32,
  parameter logic [7:0] MFR_ID  = 8'h20,
  parameter logic [7:0] DEV_ID  = 8'h5C,
  localparam int        NSECT   = 1 << SECT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic [NSECT-1:0]  prot_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [7:0]        array_data_i,
  output logic [7:0]        rd_data_o,
  output logic              rd_mode_o,
  output logic              cmd_valid_o,
  output logic [2:0]        cmd_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [7:0]        cmd_data_o,
  output logic [NSECT-1:0]  erase_mask_o,
  output logic              erase_win_o
);
  localparam int MAX_CYC = (TMO_CYC > WIN_CYC) ? TMO_CYC : WIN_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             tmr_clear, tmr_expired, ident;
  logic [CNT_W-1:0] tmr_limit;
  fcd_cmd_e         cmd;

  fcd_gap_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (tmr_clear),
    .limit_i   (tmr_limit),
    .expired_o (tmr_expired)
  );

  fcd_seq_fsm #(
    .ADDR_W (ADDR_W), .SECT_W (SECT_W), .TMO_CYC (TMO_CYC),
    .WIN_CYC(WIN_CYC), .CNT_W (CNT_W)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_i          (wr_i),
    .addr_i        (addr_i),
    .data_i        (data_i),
    .prot_i        (prot_i),
    .tmr_expired_i (tmr_expired),
    .tmr_clear_o   (tmr_clear),
    .tmr_limit_o   (tmr_limit),
    .cmd_valid_o   (cmd_valid_o),
    .cmd_o         (cmd),
    .cmd_addr_o    (cmd_addr_o),
    .cmd_data_o    (cmd_data_o),
    .erase_mask_o  (erase_mask_o),
    .ident_o       (ident),
    .erase_win_o   (erase_win_o)
  );

  fcd_read_mux #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)
  ) u_rmux (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ident_i      (ident),
    .rd_addr_i    (rd_addr_i),
    .array_data_i (array_data_i),
    .prot_i       (prot_i),
    .rd_data_o    (rd_data_o)
  );

  assign cmd_o     = cmd;
  assign rd_mode_o = ident;
endmodule

// File: tb/tb_flash_cmd_decoder.sv
`timescale 1ns/1ps
module tb_flash_cmd_decoder;
  localparam int ADDR_W = 18;
  localparam int NSECT  = 4;
  localparam int TMO    = 16;
  localparam int WIN    = 32;
  localparam logic [7:0] MFR = 8'h20;
  localparam logic [7:0] DEV = 8'h5C;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        data = '0;
  logic [NSECT-1:0]  prot = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [7:0]        arr = 8'h5A;
  logic [7:0]        rd_data;
  logic              rd_mode, cmd_valid, erase_win;
  logic [2:0]        cmd;
  logic [ADDR_W-1:0] cmd_addr;
  logic [7:0]        cmd_data;
  logic [NSECT-1:0]  emask;

  int n_chk = 0, n_fail = 0, pulses = 0;

  always #4 clk = ~clk;

  flash_cmd_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .data_i(data),
    .prot_i(prot), .rd_addr_i(rd_addr), .array_data_i(arr), .rd_data_o(rd_data),
    .rd_mode_o(rd_mode), .cmd_valid_o(cmd_valid), .cmd_o(cmd),
    .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data), .erase_mask_o(emask),
    .erase_win_o(erase_win)
  );

  always @(negedge clk) if (rst_n && cmd_valid) pulses++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_cyc(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; data = d;
    @(negedge clk); wr = 1'b0; #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic unlock();
    wr_cyc(18'h05555, 8'hAA);
    wr_cyc(18'h02AAA, 8'h55);
  endtask

  task automatic erase_head();
    unlock(); wr_cyc(18'h05555, 8'h80); unlock();
  endtask

  task automatic t_reset();
    check("R1 valid", cmd_valid, 0);
    check("R1 mode", rd_mode, 0);
    check("R1 win", erase_win, 0);
    check("R1 rdata", rd_data, 8'h5A);
  endtask

  task automatic t_program();
    int p0 = pulses;
    unlock(); wr_cyc(18'h05555, 8'hA0); wr_cyc(18'h21234, 8'h3C);
    check("R2 valid", cmd_valid, 1);
    check("R2 cmd", cmd, 1);
    check("R2 addr", cmd_addr, 18'h21234);
    check("R2 data", cmd_data, 8'h3C);
    idle(1);
    check("R2 single pulse", pulses - p0, 1);
  endtask

  task automatic t_prog_prot();
    int p0;
    prot = 4'b0100; p0 = pulses;
    unlock(); wr_cyc(18'h05555, 8'hA0); wr_cyc(18'h20010, 8'h11);
    idle(2);
    check("R3 protected dropped", pulses - p0, 0);
    unlock(); wr_cyc(18'h05555, 8'hA0); wr_cyc(18'h10010, 8'h22);
    check("R3 unprotected cmd", {cmd_valid, cmd}, {1'b1, 3'd1});
    prot = '0;
  endtask

  task automatic t_sect_erase();
    int p0;
    prot = 4'b0100; p0 = pulses;
    erase_head(); wr_cyc(18'h10000, 8'h30);
    check("R4 window open", erase_win, 1);
    wr_cyc(18'h30000, 8'h30);
    wr_cyc(18'h00000, 8'h55);
    wr_cyc(18'h20000, 8'h30);
    idle(WIN - 2);
    wr_cyc(18'h00005, 8'h30);          // lands on the expiry edge
    check("R4 late add keeps window", erase_win, 1);
    idle(WIN - 1);
    check("R4 no early pulse", pulses - p0, 0);
    idle(1);
    check("R4 erase cmd", {cmd_valid, cmd}, {1'b1, 3'd2});
    check("R4 erase mask", emask, 4'b1011);
    idle(1);
    check("R4 window closed", erase_win, 0);
    prot = '0;
  endtask

  task automatic t_sect_all_prot();
    int p0;
    prot = 4'b0100; p0 = pulses;
    erase_head(); wr_cyc(18'h20000, 8'h30);
    idle(WIN + 2);
    check("R5 no pulse", pulses - p0, 0);
    check("R5 window closed", erase_win, 0);
    prot = '0;
  endtask

  task automatic t_chip_erase();
    int p0;
    prot = 4'b0100;
    erase_head(); wr_cyc(18'h05555, 8'h10);
    check("R6 chip cmd", {cmd_valid, cmd}, {1'b1, 3'd3});
    check("R6 chip mask", emask, 4'b1011);
    prot = 4'b1111; p0 = pulses;
    erase_head(); wr_cyc(18'h05555, 8'h10);
    idle(2);
    check("R6 all protected dropped", pulses - p0, 0);
    prot = '0;
  endtask

  task automatic t_single();
    wr_cyc(18'h3ABCD, 8'hB0);
    check("R7 suspend", {cmd_valid, cmd}, {1'b1, 3'd4});
    wr_cyc(18'h12345, 8'h30);
    check("R7 resume", {cmd_valid, cmd}, {1'b1, 3'd5});
    wr_cyc(18'h00001, 8'hF0);
    check("R7 reset", {cmd_valid, cmd}, {1'b1, 3'd6});
  endtask

  task automatic t_ident();
    prot = 4'b0100;
    unlock(); wr_cyc(18'h05555, 8'h90);
    check("R9 mode", rd_mode, 1);
    rd_addr = 18'h00000; #1; check("R9 mfr", rd_data, MFR);
    rd_addr = 18'h00001; #1; check("R9 dev", rd_data, DEV);
    rd_addr = 18'h00040; #1; check("R9 other", rd_data, 8'h00);
    rd_addr = 18'h20002; #1; check("R10 protected", rd_data, 8'h01);
    rd_addr = 18'h10002; #1; check("R10 unprotected", rd_data, 8'h00);
    unlock(); wr_cyc(18'h3FFFF, 8'hF0);
    check("R8 reset cmd", {cmd_valid, cmd}, {1'b1, 3'd6});
    check("R8 mode", rd_mode, 0);
    rd_addr = '0; prot = '0;
  endtask

  task automatic t_wrong();
    int p0;
    unlock(); wr_cyc(18'h05555, 8'h90);
    p0 = pulses;
    wr_cyc(18'h05555, 8'hAA); wr_cyc(18'h02AAA, 8'h54);
    check("R11 mode cleared", rd_mode, 0);
    wr_cyc(18'h05555, 8'hA0); wr_cyc(18'h01000, 8'h77);
    wr_cyc(18'h05555, 8'hAA); wr_cyc(18'h01AAA, 8'h55);
    wr_cyc(18'h05555, 8'hA0); wr_cyc(18'h01000, 8'h77);
    idle(2);
    check("R11 no pulse", pulses - p0, 0);
  endtask

  task automatic t_timeout();
    int p0 = pulses;
    unlock(); idle(TMO - 2);
    wr_cyc(18'h05555, 8'hA0); idle(TMO - 2);
    wr_cyc(18'h00200, 8'h42);
    check("R12 max gap accepted", {cmd_valid, cmd}, {1'b1, 3'd1});
    p0 = pulses;
    unlock(); idle(TMO - 1);
    wr_cyc(18'h05555, 8'hA0); wr_cyc(18'h00200, 8'h42);
    idle(2);
    check("R12 timeout aborts", pulses - p0, 0);
  endtask

  task automatic t_addr15();
    wr_cyc(18'h1D555, 8'hAA); wr_cyc(18'h2AAAA, 8'h55);
    wr_cyc(18'h25555, 8'hA0); wr_cyc(18'h00100, 8'h99);
    check("R13 upper bits ignored", {cmd_valid, cmd, cmd_data}, {1'b1, 3'd1, 8'h99});
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_program();
    t_prog_prot();
    t_sect_erase();
    t_sect_all_prot();
    t_chip_erase();
    t_single();
    t_ident();
    t_wrong();
    t_timeout();
    t_addr15();
    summary();
    $finish;
  end
endmodule